// File: doc/BRIEF.md
# Cache Miss-Buffer Admission Controller

This block decides whether the CPU-side request path of a cache may accept new work. It keeps an occupancy count for two entry pools. The first pool tracks outstanding misses and also takes uncached reads and prefetches. The second pool holds writes. Each pool is filled by an allocation and drained by a mark-in-service event. The block also accepts an external "no free target slot" condition. The three reasons for refusing work are kept as separate bits of a cause mask. The CPU-side port is ready only while that mask is empty.

When an allocation is accepted, the block returns the entry descriptor: the address, the size and a running order tag. It can also raise a memory-side bus request, which carries the reason for the request. A requester that was refused while the path was blocked is owed a retry. The retry is a one-cycle pulse issued on the cycle the path opens again. The block keeps saturating statistics for each cause: how many blocking episodes that cause started, and how many cycles those episodes lasted.

Top module: `mbuf_block_ctrl`

## Requirements
- R1: After a synchronous reset, `cpu_ready` is 1, and the cause mask, both pool counts, all statistics, the order tag and every pulse output are 0.
- R2: The cause mask bits are bit 0 = miss pool full, bit 1 = write pool full and bit 2 = no target slot. `cpu_ready` is 0 exactly when any bit is set. All registered outputs change on the clock edge that samples their inputs.
- R3: An accepted allocation raises its pool's count by one. The allocation kind selects the pool: 0 = miss, 1 = write, 2 = uncached read, 3 = prefetch. Kind 1 goes to the write pool and every other kind goes to the miss pool. When the count reaches the pool depth, that pool's mask bit is set on the same edge.
- R4: A mark-in-service event lowers its pool's count by one. If the pool was full, the event clears that pool's mask bit. A mark-in-service event on an empty pool has no effect.
- R5: An allocation aimed at a pool that is already full is ignored. It pulses `alloc_err` instead of `alloc_ok`, and the count never exceeds the depth. This holds even when a mark-in-service event hits the same pool in the same cycle.
- R6: Kinds 0 and 3 return the address with the low log2(BLK_BYTES) bits cleared and a size of BLK_BYTES. Kinds 1 and 2 return the request's own address and size.
- R7: Each accepted allocation returns the current order tag, and the tag then advances by one. Rejected allocations leave the tag unchanged.
- R8: When `alloc_bus` is set on an accepted allocation, `bus_req` pulses with `bus_cause`. The cause is 0 for kinds 0 and 2, 1 for kind 1, and 2 for kind 3. A rejected allocation never requests the bus.
- R9: When the mask goes from empty to non-empty, the event count of each cause whose bit is newly set increases by one. Cause i's count sits at `blk_events[i*EVT_W +: EVT_W]`.
- R10: When the mask goes from non-empty to empty, each cause whose bit clears adds the number of cycles the mask was non-empty. Cause i's total sits at `blk_cycles[i*CYC_W +: CYC_W]`.
- R11: A request on `cpu_req` while `cpu_ready` is 0 makes a retry owed. On the edge where the mask becomes empty, an owed retry, or a refusal in that same cycle, produces a single `retry` pulse, and the debt is then cleared.
- R12: The event and cycle statistics saturate at their all-ones value instead of wrapping.
- R13: `tgt_set` sets mask bit 2 and `tgt_clr` clears it. When both are asserted together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_kind | input | 2 | Allocation kind (0 miss, 1 write, 2 uncached read, 3 prefetch) |
| alloc_addr | input | ADDR_W | Request address |
| alloc_size | input | SIZE_W | Request size in bytes |
| alloc_bus | input | 1 | Raise a memory-side bus request with this allocation |
| svc_miss | input | 1 | Mark one miss-pool entry in service |
| svc_wr | input | 1 | Mark one write-pool entry in service |
| tgt_set | input | 1 | Assert the no-target-slot cause |
| tgt_clr | input | 1 | Release the no-target-slot cause |
| cpu_req | input | 1 | CPU-side request presented this cycle |
| cpu_ready | output | 1 | Path accepts requests |
| retry | output | 1 | Retry pulse to the refused requester |
| blk_mask | output | 3 | Cause mask |
| miss_used | output | $clog2(MISS_DEPTH+1) | Miss-pool occupancy |
| wr_used | output | $clog2(WB_DEPTH+1) | Write-pool occupancy |
| alloc_ok | output | 1 | Allocation accepted (pulse) |
| alloc_err | output | 1 | Allocation rejected, pool full (pulse) |
| ent_addr | output | ADDR_W | Descriptor address |
| ent_size | output | SIZE_W | Descriptor size |
| ent_order | output | ORDER_W | Descriptor order tag |
| bus_req | output | 1 | Memory-side bus request (pulse) |
| bus_cause | output | 2 | Reason for the bus request |
| blk_events | output | 3*EVT_W | Blocking-episode counts per cause |
| blk_cycles | output | 3*CYC_W | Blocked-cycle totals per cause |

## Verification
Two kinds of collision are forced on purpose. In the first, an allocation and a mark-in-service event hit a full miss pool in the same cycle. The allocation must be rejected while the service still opens the path. In the second, a fresh refusal arrives in the very cycle the last cause clears. Both are judged against a behavioural model that applies the same inputs and compares every output after each edge. The model is first driven by directed sequences and then by a long random run. The random run also pushes the event counters into saturation.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    localparam int NCAUSE = 3;

    typedef enum logic [1:0] {
        CAUSE_MISS = 2'd0,
        CAUSE_WR   = 2'd1,
        CAUSE_TGT  = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        K_MISS   = 2'd0,
        K_WRITE  = 2'd1,
        K_UNC_RD = 2'd2,
        K_PREF   = 2'd3
    } akind_e;

    function automatic logic goes_to_miss_pool(akind_e k);
        return k != K_WRITE;
    endfunction

    function automatic logic is_block_kind(akind_e k);
        return (k == K_MISS) || (k == K_PREF);
    endfunction

    function automatic logic [1:0] bus_reason(akind_e k);
        case (k)
            K_WRITE: return 2'd1;
            K_PREF:  return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/mbc_pool.sv
module mbc_pool #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_i,
    input  logic          svc_i,
    output logic          acc_o,
    output logic          err_o,
    output logic          full_next_o,
    output logic [CW-1:0] count_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          is_full;
    logic          dec;

    always_comb begin
        is_full     = (cnt_q == CW'(DEPTH));
        acc_o       = alloc_i && !is_full;
        err_o       = alloc_i && is_full;
        dec         = svc_i && (cnt_q != '0);
        cnt_d       = cnt_q + (acc_o ? CW'(1) : CW'(0)) - (dec ? CW'(1) : CW'(0));
        full_next_o = (cnt_d == CW'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/mbc_block_track.sv
module mbc_block_track #(
    parameter int NC    = 3,
    parameter int EVT_W = 8,
    parameter int CYC_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NC-1:0]       mask_next_i,
    input  logic                cpu_req_i,
    output logic [NC-1:0]       mask_o,
    output logic                ready_o,
    output logic                retry_o,
    output logic [NC*EVT_W-1:0] evt_o,
    output logic [NC*CYC_W-1:0] cyc_o
);
    logic [NC-1:0]    mask_q;
    logic             owed_q;
    logic             retry_q;
    logic [CYC_W-1:0] now_q;
    logic [CYC_W-1:0] start_q;
    logic             rise;
    logic             fall;
    logic             refused;
    logic [CYC_W-1:0] elapsed;

    always_comb begin
        rise    = (mask_q == '0) && (mask_next_i != '0);
        fall    = (mask_q != '0) && (mask_next_i == '0);
        refused = cpu_req_i && (mask_q != '0);
        elapsed = now_q - start_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            owed_q  <= 1'b0;
            retry_q <= 1'b0;
            now_q   <= '0;
            start_q <= '0;
        end else begin
            mask_q  <= mask_next_i;
            now_q   <= now_q + CYC_W'(1);
            retry_q <= (owed_q || refused) && fall;
            owed_q  <= (owed_q || refused) && !fall;
            if (rise) start_q <= now_q;
        end
    end

    for (genvar i = 0; i < NC; i++) begin : g_stat
        logic [EVT_W-1:0] evt_q;
        logic [CYC_W:0]   sum;
        logic [CYC_W-1:0] tot_q;

        assign sum = {1'b0, tot_q} + {1'b0, elapsed};

        always_ff @(posedge clk) begin
            if (rst) begin
                evt_q <= '0;
                tot_q <= '0;
            end else begin
                if (rise && mask_next_i[i] && (evt_q != '1))
                    evt_q <= evt_q + EVT_W'(1);
                if (fall && mask_q[i])
                    tot_q <= sum[CYC_W] ? '1 : sum[CYC_W-1:0];
            end
        end

        assign evt_o[i*EVT_W +: EVT_W] = evt_q;
        assign cyc_o[i*CYC_W +: CYC_W] = tot_q;
    end

    assign mask_o  = mask_q;
    assign ready_o = (mask_q == '0);
    assign retry_o = retry_q;
endmodule

// File: rtl/mbuf_block_ctrl.sv
module mbuf_block_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 8,
    parameter int BLK_BYTES  = 64,
    parameter int MISS_DEPTH = 4,
    parameter int WB_DEPTH   = 2,
    parameter int ORDER_W    = 16,
    parameter int EVT_W      = 8,
    parameter int CYC_W      = 16
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               alloc_valid,
    input  logic [1:0]                         alloc_kind,
    input  logic [ADDR_W-1:0]                  alloc_addr,
    input  logic [SIZE_W-1:0]                  alloc_size,
    input  logic                               alloc_bus,
    input  logic                               svc_miss,
    input  logic                               svc_wr,
    input  logic                               tgt_set,
    input  logic                               tgt_clr,
    input  logic                               cpu_req,
    output logic                               cpu_ready,
    output logic                               retry,
    output logic [2:0]                         blk_mask,
    output logic [$clog2(MISS_DEPTH+1)-1:0]    miss_used,
    output logic [$clog2(WB_DEPTH+1)-1:0]      wr_used,
    output logic                               alloc_ok,
    output logic                               alloc_err,
    output logic [ADDR_W-1:0]                  ent_addr,
    output logic [SIZE_W-1:0]                  ent_size,
    output logic [ORDER_W-1:0]                 ent_order,
    output logic                               bus_req,
    output logic [1:0]                         bus_cause,
    output logic [3*EVT_W-1:0]                 blk_events,
    output logic [3*CYC_W-1:0]                 blk_cycles
);
    import mbc_pkg::*;

    localparam int OFS_BITS = $clog2(BLK_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << OFS_BITS) - ADDR_W'(1));

    akind_e kind;
    logic   to_miss;
    logic   m_acc, m_err, m_full_n;
    logic   w_acc, w_err, w_full_n;
    logic   acc, err;
    logic [NCAUSE-1:0] mask_q;
    logic [NCAUSE-1:0] mask_n;

    assign kind    = akind_e'(alloc_kind);
    assign to_miss = goes_to_miss_pool(kind);

    mbc_pool #(.DEPTH(MISS_DEPTH)) u_miss_pool (
        .clk(clk), .rst(rst),
        .alloc_i(alloc_valid && to_miss), .svc_i(svc_miss),
        .acc_o(m_acc), .err_o(m_err), .full_next_o(m_full_n),
        .count_o(miss_used)
    );

    mbc_pool #(.DEPTH(WB_DEPTH)) u_wr_pool (
        .clk(clk), .rst(rst),
        .alloc_i(alloc_valid && !to_miss), .svc_i(svc_wr),
        .acc_o(w_acc), .err_o(w_err), .full_next_o(w_full_n),
        .count_o(wr_used)
    );

    assign acc = m_acc || w_acc;
    assign err = m_err || w_err;

    always_comb begin
        mask_n            = '0;
        mask_n[CAUSE_MISS] = m_full_n;
        mask_n[CAUSE_WR]   = w_full_n;
        mask_n[CAUSE_TGT]  = tgt_set || (mask_q[CAUSE_TGT] && !tgt_clr);
    end

    mbc_block_track #(.NC(NCAUSE), .EVT_W(EVT_W), .CYC_W(CYC_W)) u_track (
        .clk(clk), .rst(rst),
        .mask_next_i(mask_n), .cpu_req_i(cpu_req),
        .mask_o(mask_q), .ready_o(cpu_ready), .retry_o(retry),
        .evt_o(blk_events), .cyc_o(blk_cycles)
    );

    assign blk_mask = mask_q;

    logic [ORDER_W-1:0] order_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            order_q   <= '0;
            alloc_ok  <= 1'b0;
            alloc_err <= 1'b0;
            ent_addr  <= '0;
            ent_size  <= '0;
            ent_order <= '0;
            bus_req   <= 1'b0;
            bus_cause <= '0;
        end else begin
            alloc_ok  <= acc;
            alloc_err <= err;
            bus_req   <= acc && alloc_bus;
            if (acc) begin
                order_q   <= order_q + ORDER_W'(1);
                ent_order <= order_q;
                ent_addr  <= is_block_kind(kind) ? (alloc_addr & ALIGN_MASK) : alloc_addr;
                ent_size  <= is_block_kind(kind) ? SIZE_W'(BLK_BYTES) : alloc_size;
                bus_cause <= bus_reason(kind);
            end
        end
    end
endmodule

// File: rtl/mbc_checker.sv
module mbc_checker #(
    parameter int MISS_DEPTH = 4,
    parameter int WB_DEPTH   = 2,
    parameter int ORDER_W    = 16
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            cpu_ready,
    input logic                            retry,
    input logic [2:0]                      blk_mask,
    input logic [$clog2(MISS_DEPTH+1)-1:0] miss_used,
    input logic [$clog2(WB_DEPTH+1)-1:0]   wr_used,
    input logic                            alloc_ok,
    input logic                            alloc_err,
    input logic [ORDER_W-1:0]              ent_order,
    input logic                            bus_req
);
    a_r3_full_sets_bit: assert property (@(posedge clk) disable iff (rst)
        (miss_used == MISS_DEPTH) == blk_mask[0]);

    a_r3_wr_full_bit: assert property (@(posedge clk) disable iff (rst)
        (wr_used == WB_DEPTH) == blk_mask[1]);

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (miss_used <= MISS_DEPTH) && (wr_used <= WB_DEPTH));

    a_r5_ok_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(alloc_ok && alloc_err));

    a_r8_bus_needs_ok: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> alloc_ok);

    a_r11_retry_on_open: assert property (@(posedge clk) disable iff (rst)
        retry |-> (cpu_ready && $past(!cpu_ready)));

    a_r7_order_step: assert property (@(posedge clk) disable iff (rst)
        (alloc_ok && $past(alloc_ok)) |-> (ent_order == $past(ent_order) + ORDER_W'(1)));
endmodule

bind mbuf_block_ctrl mbc_checker #(
    .MISS_DEPTH(MISS_DEPTH), .WB_DEPTH(WB_DEPTH), .ORDER_W(ORDER_W)
) u_chk (
    .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .retry(retry),
    .blk_mask(blk_mask), .miss_used(miss_used), .wr_used(wr_used),
    .alloc_ok(alloc_ok), .alloc_err(alloc_err), .ent_order(ent_order),
    .bus_req(bus_req)
);

// File: tb/sim_mbuf_block_ctrl.sv
`timescale 1ns/1ps
module sim_mbuf_block_ctrl;
    localparam int MD = 4, WD = 2, BLK = 64, EW = 3, CW = 16, OW = 16;
    localparam int EVMAX = 7, CYMAX = 65535;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        alloc_valid = 0, alloc_bus = 0, svc_miss = 0, svc_wr = 0;
    logic        tgt_set = 0, tgt_clr = 0, cpu_req = 0;
    logic [1:0]  alloc_kind = 0;
    logic [31:0] alloc_addr = 0;
    logic [7:0]  alloc_size = 0;

    logic        cpu_ready, retry, alloc_ok, alloc_err, bus_req;
    logic [2:0]  blk_mask;
    logic [2:0]  miss_used;
    logic [1:0]  wr_used;
    logic [31:0] ent_addr;
    logic [7:0]  ent_size;
    logic [OW-1:0] ent_order;
    logic [1:0]  bus_cause;
    logic [3*EW-1:0] blk_events;
    logic [3*CW-1:0] blk_cycles;

    mbuf_block_ctrl #(.MISS_DEPTH(MD), .WB_DEPTH(WD), .BLK_BYTES(BLK),
                      .ORDER_W(OW), .EVT_W(EW), .CYC_W(CW)) u0 (.*);

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model state
    int m_miss, m_wr, m_mask, m_owed, m_order, m_run;
    int m_evt[3], m_tot[3];
    int m_ok, m_err, m_addr, m_size, m_ord, m_bus, m_bcause, m_retry;

    task automatic chk(input bit good, input string tag, input longint act, input longint exp);
        checks++;
        if (!good) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_miss = 0; m_wr = 0; m_mask = 0; m_owed = 0; m_order = 0; m_run = 0;
        for (int i = 0; i < 3; i++) begin m_evt[i] = 0; m_tot[i] = 0; end
        m_ok = 0; m_err = 0; m_addr = 0; m_size = 0; m_ord = 0;
        m_bus = 0; m_bcause = 0; m_retry = 0;
    endtask

    task automatic model_step();
        int to_miss, full, ok, nm, nw, nmask, refuse, open_now, kind;
        kind = alloc_kind;
        to_miss = (kind != 1);
        full = to_miss ? (m_miss == MD) : (m_wr == WD);
        ok = alloc_valid && !full;
        nm = m_miss + ((ok && to_miss) ? 1 : 0) - ((svc_miss && m_miss > 0) ? 1 : 0);
        nw = m_wr + ((ok && !to_miss) ? 1 : 0) - ((svc_wr && m_wr > 0) ? 1 : 0);
        nmask = ((nm == MD) ? 1 : 0) | ((nw == WD) ? 2 : 0);
        if (tgt_set || (((m_mask >> 2) & 1) && !tgt_clr)) nmask |= 4;
        if (m_mask == 0 && nmask != 0)
            for (int i = 0; i < 3; i++)
                if (((nmask >> i) & 1) && m_evt[i] < EVMAX) m_evt[i]++;
        if (m_mask != 0) m_run++;
        open_now = (m_mask != 0) && (nmask == 0);
        if (open_now) begin
            for (int i = 0; i < 3; i++)
                if ((m_mask >> i) & 1) m_tot[i] = (m_tot[i] + m_run > CYMAX) ? CYMAX : m_tot[i] + m_run;
            m_run = 0;
        end
        refuse = cpu_req && (m_mask != 0);
        m_retry = (m_owed || refuse) && open_now;
        m_owed = (m_owed || refuse) && !open_now;
        m_ok = ok; m_err = alloc_valid && full;
        m_bus = ok && alloc_bus;
        if (ok) begin
            m_ord = m_order; m_order = (m_order + 1) % 65536;
            m_addr = (kind == 0 || kind == 3) ? (alloc_addr & ~(BLK - 1)) : alloc_addr;
            m_size = (kind == 0 || kind == 3) ? BLK : alloc_size;
            m_bcause = (kind == 1) ? 1 : (kind == 3) ? 2 : 0;
        end
        m_miss = nm; m_wr = nw; m_mask = nmask;
    endtask

    task automatic compare();
        chk(cpu_ready == (m_mask == 0), "R2 cpu_ready", cpu_ready, m_mask == 0);
        chk(blk_mask == m_mask, "R2/R13 blk_mask", blk_mask, m_mask);
        chk(miss_used == m_miss, "R3/R4 miss_used", miss_used, m_miss);
        chk(wr_used == m_wr, "R3/R4 wr_used", wr_used, m_wr);
        chk(alloc_ok == m_ok, "R5 alloc_ok", alloc_ok, m_ok);
        chk(alloc_err == m_err, "R5 alloc_err", alloc_err, m_err);
        chk(retry == m_retry, "R11 retry", retry, m_retry);
        chk(bus_req == m_bus, "R8 bus_req", bus_req, m_bus);
        if (m_ok) begin
            chk(ent_addr == m_addr, "R6 ent_addr", ent_addr, m_addr);
            chk(ent_size == m_size, "R6 ent_size", ent_size, m_size);
            chk(ent_order == m_ord, "R7 ent_order", ent_order, m_ord);
        end
        if (m_bus) chk(bus_cause == m_bcause, "R8 bus_cause", bus_cause, m_bcause);
        for (int i = 0; i < 3; i++) begin
            chk(blk_events[i*EW +: EW] == m_evt[i], "R9/R12 blk_events", blk_events[i*EW +: EW], m_evt[i]);
            chk(blk_cycles[i*CW +: CW] == m_tot[i], "R10 blk_cycles", blk_cycles[i*CW +: CW], m_tot[i]);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_bus = 0; svc_miss = 0; svc_wr = 0;
        tgt_set = 0; tgt_clr = 0; cpu_req = 0;
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        idle();
    endtask

    task automatic alloc(input int k, input logic [31:0] a, input int sz, input bit b);
        alloc_valid = 1; alloc_kind = 2'(k); alloc_addr = a; alloc_size = 8'(sz); alloc_bus = b;
    endtask

    initial begin
        idle();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state
        chk(cpu_ready == 1, "R1 ready", cpu_ready, 1);
        chk(blk_mask == 0, "R1 mask", blk_mask, 0);
        chk(ent_order == 0 && alloc_ok == 0 && retry == 0, "R1 pulses", alloc_ok, 0);
        chk(blk_events == 0 && blk_cycles == 0, "R1 stats", blk_events, 0);
        // R3 R6 R8: fill miss pool with aligned misses
        for (int i = 0; i < MD; i++) begin
            alloc(0, 32'h1000_0000 + 32'(i * 77), 5, 1); cpu_req = 1; step();
        end
        // R5: allocate into full pool
        alloc(3, 32'h2345, 1, 1); step();
        for (int i = 0; i < 3; i++) begin cpu_req = 1; step(); end
        // R5 R11: alloc and service collide on full pool
        alloc(2, 32'h55, 4, 1); svc_miss = 1; step();
        step();
        // R3 R13: write pool full, then target cause overlaps
        alloc(1, 32'h7777, 8, 1); step();
        alloc(1, 32'h7779, 2, 0); step();
        tgt_set = 1; tgt_clr = 1; step();
        svc_wr = 1; cpu_req = 1; step();
        step();
        // R11: refusal in the cycle the last cause clears
        tgt_clr = 1; cpu_req = 1; step();
        step();
        // R4: service on empty write pool
        svc_wr = 1; step(); svc_wr = 1; step(); svc_wr = 1; step();
        alloc(3, 32'hABCD_EF01, 9, 1); step();
        // random run, pushes R12 saturation
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 1) == 1)
                alloc(int'($urandom_range(0, 3)), $urandom, int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
            svc_miss = ($urandom_range(0, 3) == 0);
            svc_wr   = ($urandom_range(0, 3) == 0);
            tgt_set  = ($urandom_range(0, 19) == 0);
            tgt_clr  = ($urandom_range(0, 7) == 0);
            cpu_req  = 1'($urandom_range(0, 1));
            step();
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule